// File: doc/BRIEF.md
# Match-Capture Timer-Counter

A 32-bit timer-counter peripheral sitting on a simple single-cycle register bus. The counter either advances on a prescaled system clock (timer mode) or on synchronized edges of one of the two capture pins (counter mode). Four compare channels watch the count. Each one can raise an interrupt flag, return the count to zero, or halt counting. Each one also drives a dedicated output pin through a programmable 2-bit action.

Two capture channels copy the live count into read-only holding registers when a chosen pin edge occurs, and can raise flags of their own. All flags live in one write-one-to-clear register, and their OR forms the interrupt line. Software writes registers with a one-cycle write strobe, and reads are combinational on the address.

Register indices on `bus_addr`: 0 flags, 1 control, 2 count, 3 prescale limit, 4 prescale count (read-only), 5 compare control, 6..9 compare values 0..3, 10 capture control, 11..12 capture values 0..1 (read-only), 13 output control, 14 count mode. Unused indices and unused bits read 0.

Top module: `mc_timer`

## Requirements
- R1: Writable fields are masked on write and read back as follows: control bits 1:0, compare control bits 11:0, capture control bits 5:0, output control bits 11:0, count mode bits 3:0, flags bits 5:0, and prescale limit, compare values and count at full width. Writes to the prescale count (index 4) and the capture values (indices 11, 12) are ignored.
- R2: Control bit 0 enables counting. While control bit 1 is 1, the count and the prescale count are held at 0, and bus writes to the count have no effect.
- R3: In timer mode (count mode bits 1:0 = 0) with prescale limit P, the prescale count runs 0..P and wraps. On each wrap the count increments, so the count advances once every P+1 clocks after enabling.
- R4: In counter mode, bits 1:0 = 1 count rising edges, 2 falling edges and 3 both edges of the source pin. Bits 3:2 pick the source: 0 selects `cap_in[0]`, 1 selects `cap_in[1]`, and 2 or 3 select no pin. Pins pass a two-flop synchronizer, and edges of the unselected pin do not count.
- R5: A compare event for channel n happens on a count advance tick in which the count equals compare value n. If compare control bit 3n is set, flag bit n is set. Otherwise the event sets no flag.
- R6: If compare control bit 3n+1 is set, the tick carrying the compare event loads the count with 0 instead of incrementing it.
- R7: If compare control bit 3n+2 is set (and reset is not), the event tick leaves the count at the compare value and clears control bit 0.
- R8: Output control bits 3:0 are the levels on `mat_out`. Channel n uses the action field at bits 5+2n:4+2n: 00 keep, 01 drive low, 10 drive high, 11 toggle. The action applies on each compare event and takes priority over a same-cycle bus write to that bit.
- R9: Capture control bit 3n selects rising edges and bit 3n+1 selects falling edges of `cap_in[n]`; both set means any edge. On a selected edge, capture value n takes the count held in the cycle the synchronized edge is detected.
- R10: If capture control bit 3n+2 is set, a capture on channel n sets flag bit 4+n.
- R11: Writing 1 to a flag bit clears it. An event in the same cycle as the clear leaves the flag set. `irq` is high when any flag is set.
- R12: Capture remains active on the pin that is the count source. It latches the count from before the increment caused by the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| cap_in | input | 2 | Capture and count-source pins, asynchronous |
| mat_out | output | 4 | Compare output pin levels |
| irq | output | 1 | OR of all pending flags |

## Verification
Two functions can collide in one cycle: a software write-one-to-clear of a compare flag, and a new compare event on the same flag. The bench runs the counter with prescale 0 and a resetting compare channel, so the event edge is known exactly. It times the clear write to land on that edge, and then expects the flag to read 1. A later clear with the counter halted must read 0, which shows that the clear itself works. The same priority rule between a compare action and a bus write to the output levels is guarded by an assertion that the toggle action always changes the pin.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
  localparam int MATCH_N = 4;
  localparam int CAP_N   = 2;
  localparam int ADDR_W  = 4;
  localparam int IRQ_W   = MATCH_N + CAP_N;
  localparam int MCTL_W  = 3 * MATCH_N;
  localparam int CCTL_W  = 3 * CAP_N;
  localparam int EXTM_W  = MATCH_N + 2 * MATCH_N;
  localparam int CMODE_W = 4;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } ext_act_e;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_RISE  = 2'd1,
    MODE_FALL  = 2'd2,
    MODE_BOTH  = 2'd3
  } cnt_mode_e;

  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd3;
  localparam logic [ADDR_W-1:0] A_PCNT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MCTL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd6;
  localparam logic [ADDR_W-1:0] A_CCTL   = 4'd10;
  localparam logic [ADDR_W-1:0] A_CAPT0  = 4'd11;
  localparam logic [ADDR_W-1:0] A_EXTM   = 4'd13;
  localparam logic [ADDR_W-1:0] A_CMODE  = 4'd14;

  function automatic logic ext_next(ext_act_e act, logic cur);
    case (act)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~cur;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/mct_sync_edge.sv
`timescale 1ns/1ps
module mct_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // [0] first sync stage, [1] second sync stage, [2] previous synced value
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];

  AST_EDGE_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(sh_q[0])); // R9
endmodule

// File: rtl/mct_prescaler.sv
`timescale 1ns/1ps
module mct_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pcount,
  output logic         wrap
);
  logic [W-1:0] pc_q;
  logic [W-1:0] pc_d;

  // >= keeps the wrap reachable after the limit is lowered mid-period
  assign wrap = run & (pc_q >= limit);

  always_comb begin
    pc_d = pc_q;
    if (clr)       pc_d = '0;
    else if (wrap) pc_d = '0;
    else if (run)  pc_d = pc_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pcount = pc_q;

  AST_PRESCALE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pcount == '0)); // R3
  AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pcount)); // R3
endmodule

// File: rtl/mct_match_unit.sv
`timescale 1ns/1ps
module mct_match_unit
  import mct_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] match_val,
  input  logic         tick,
  input  logic [2:0]   cfg,      // {stop, reset, irq}
  input  logic [1:0]   act,
  input  logic         level,
  output logic         evt,
  output logic         want_irq,
  output logic         want_rst,
  output logic         want_stop,
  output logic         level_d
);
  always_comb begin
    evt       = tick & (count == match_val);
    want_irq  = evt & cfg[0];
    want_rst  = evt & cfg[1];
    want_stop = evt & cfg[2];
    level_d   = evt ? ext_next(ext_act_e'(act), level) : level;
  end
endmodule

// File: rtl/mc_timer.sv
`timescale 1ns/1ps
module mc_timer
  import mct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CAP_N-1:0]  cap_in,
  output logic [MATCH_N-1:0] mat_out,
  output logic              irq
);
  // ---------------- state ----------------
  logic               en_q, en_d;
  logic               crst_q, crst_d;
  logic [CNT_W-1:0]   tc_q, tc_d;
  logic [CNT_W-1:0]   presc_q, presc_d;
  logic [MCTL_W-1:0]  mctl_q, mctl_d;
  logic [CCTL_W-1:0]  cctl_q, cctl_d;
  logic [EXTM_W-1:0]  extm_q, extm_d;
  logic [CMODE_W-1:0] cmode_q, cmode_d;
  logic [IRQ_W-1:0]   flags_q, flags_d;
  logic [CNT_W-1:0]   mval_q [MATCH_N];
  logic [CNT_W-1:0]   capt_q [CAP_N];

  // ---------------- bus decode ----------------
  logic wr_flags, wr_ctrl, wr_count, wr_presc, wr_mctl, wr_cctl, wr_extm, wr_cmode;
  logic [MATCH_N-1:0] wr_mval;

  always_comb begin
    wr_flags = bus_we && (bus_addr == A_FLAGS);
    wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    wr_count = bus_we && (bus_addr == A_COUNT);
    wr_presc = bus_we && (bus_addr == A_PRESC);
    wr_mctl  = bus_we && (bus_addr == A_MCTL);
    wr_cctl  = bus_we && (bus_addr == A_CCTL);
    wr_extm  = bus_we && (bus_addr == A_EXTM);
    wr_cmode = bus_we && (bus_addr == A_CMODE);
    for (int n = 0; n < MATCH_N; n++)
      wr_mval[n] = bus_we && (bus_addr == A_MATCH0 + ADDR_W'(n));
  end

  // ---------------- pin edges ----------------
  logic [CAP_N-1:0] c_rise, c_fall, c_evt, c_irq;

  for (genvar n = 0; n < CAP_N; n++) begin : g_cap
    mct_sync_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_in[n]),
      .rise (c_rise[n]),
      .fall (c_fall[n])
    );
    assign c_evt[n] = (c_rise[n] & cctl_q[3*n]) | (c_fall[n] & cctl_q[3*n+1]);
    assign c_irq[n] = c_evt[n] & cctl_q[3*n+2];
  end

  // ---------------- tick generation ----------------
  cnt_mode_e  mode;
  logic [1:0] src_sel;
  logic       src_rise, src_fall, cnt_edge, timer_mode, run_ok, pre_wrap, tick;
  logic [CNT_W-1:0] pcount;

  always_comb begin
    mode       = cnt_mode_e'(cmode_q[1:0]);
    src_sel    = cmode_q[3:2];
    timer_mode = (mode == MODE_TIMER);
    run_ok     = en_q & ~crst_q;
    src_rise   = 1'b0;
    src_fall   = 1'b0;
    if (src_sel == 2'd0) begin
      src_rise = c_rise[0];
      src_fall = c_fall[0];
    end else if (src_sel == 2'd1) begin
      src_rise = c_rise[1];
      src_fall = c_fall[1];
    end
    case (mode)
      MODE_RISE: cnt_edge = src_rise;
      MODE_FALL: cnt_edge = src_fall;
      MODE_BOTH: cnt_edge = src_rise | src_fall;
      default:   cnt_edge = 1'b0;
    endcase
    tick = run_ok & (timer_mode ? pre_wrap : cnt_edge);
  end

  mct_prescaler #(.W(CNT_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_ok & timer_mode),
    .clr   (crst_q),
    .limit (presc_q),
    .pcount(pcount),
    .wrap  (pre_wrap)
  );

  // ---------------- compare channels ----------------
  logic [MATCH_N-1:0] m_evt, m_irq, m_rst, m_stop, m_lvl;
  logic any_rst, any_stop;

  for (genvar n = 0; n < MATCH_N; n++) begin : g_match
    mct_match_unit #(.W(CNT_W)) u_match (
      .count    (tc_q),
      .match_val(mval_q[n]),
      .tick     (tick),
      .cfg      (mctl_q[3*n +: 3]),
      .act      (extm_q[MATCH_N + 2*n +: 2]),
      .level    (extm_q[n]),
      .evt      (m_evt[n]),
      .want_irq (m_irq[n]),
      .want_rst (m_rst[n]),
      .want_stop(m_stop[n]),
      .level_d  (m_lvl[n])
    );

    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (m_evt[n] && mctl_q[3*n]) |=> flags_q[n]); // R5
    AST_EXT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (m_evt[n] && (extm_q[MATCH_N + 2*n +: 2] == 2'b11)) |=> (mat_out[n] != $past(mat_out[n]))); // R8
  end

  assign any_rst  = |m_rst;
  assign any_stop = |m_stop;

  // ---------------- next state ----------------
  always_comb begin
    en_d    = en_q;
    crst_d  = crst_q;
    tc_d    = tc_q;
    presc_d = wr_presc ? bus_wdata : presc_q;
    mctl_d  = wr_mctl  ? bus_wdata[MCTL_W-1:0]  : mctl_q;
    cctl_d  = wr_cctl  ? bus_wdata[CCTL_W-1:0]  : cctl_q;
    cmode_d = wr_cmode ? bus_wdata[CMODE_W-1:0] : cmode_q;

    if (wr_ctrl) begin
      en_d   = bus_wdata[0];
      crst_d = bus_wdata[1];
    end else if (any_stop) begin
      en_d = 1'b0;
    end

    if (crst_q)        tc_d = '0;
    else if (wr_count) tc_d = bus_wdata;
    else if (tick) begin
      if (any_rst)        tc_d = '0;
      else if (!any_stop) tc_d = tc_q + CNT_W'(1);
    end

    flags_d = wr_flags ? (flags_q & ~bus_wdata[IRQ_W-1:0]) : flags_q;
    flags_d = flags_d | {c_irq, m_irq};

    extm_d = wr_extm ? bus_wdata[EXTM_W-1:0] : extm_q;
    for (int n = 0; n < MATCH_N; n++)
      if (m_evt[n]) extm_d[n] = m_lvl[n];
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      crst_q  <= 1'b0;
      tc_q    <= '0;
      presc_q <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      extm_q  <= '0;
      cmode_q <= '0;
      flags_q <= '0;
    end else begin
      en_q    <= en_d;
      crst_q  <= crst_d;
      tc_q    <= tc_d;
      presc_q <= presc_d;
      mctl_q  <= mctl_d;
      cctl_q  <= cctl_d;
      extm_q  <= extm_d;
      cmode_q <= cmode_d;
      flags_q <= flags_d;
    end
  end

  for (genvar n = 0; n < MATCH_N; n++) begin : g_mval
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mval_q[n] <= '0;
      else if (wr_mval[n]) mval_q[n] <= bus_wdata;
    end
  end

  for (genvar n = 0; n < CAP_N; n++) begin : g_capt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        capt_q[n] <= '0;
      else if (c_evt[n]) capt_q[n] <= tc_q;
    end

    AST_CAPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      c_evt[n] |=> (capt_q[n] == $past(tc_q))); // R9
    AST_CAPT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      c_irq[n] |=> flags_q[MATCH_N + n]); // R10
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_FLAGS: bus_rdata[IRQ_W-1:0]   = flags_q;
      A_CTRL:  bus_rdata[1:0]         = {crst_q, en_q};
      A_COUNT: bus_rdata              = tc_q;
      A_PRESC: bus_rdata              = presc_q;
      A_PCNT:  bus_rdata              = pcount;
      A_MCTL:  bus_rdata[MCTL_W-1:0]  = mctl_q;
      A_CCTL:  bus_rdata[CCTL_W-1:0]  = cctl_q;
      A_EXTM:  bus_rdata[EXTM_W-1:0]  = extm_q;
      A_CMODE: bus_rdata[CMODE_W-1:0] = cmode_q;
      default: ;
    endcase
    for (int n = 0; n < MATCH_N; n++)
      if (bus_addr == A_MATCH0 + ADDR_W'(n)) bus_rdata = mval_q[n];
    for (int n = 0; n < CAP_N; n++)
      if (bus_addr == A_CAPT0 + ADDR_W'(n)) bus_rdata = capt_q[n];
  end

  assign mat_out = extm_q[MATCH_N-1:0];
  assign irq     = |flags_q;

  // ---------------- assertions ----------------
  AST_RST_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    crst_q |=> (tc_q == '0)); // R2
  AST_RESET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rst && !crst_q && !wr_count) |=> (tc_q == '0)); // R6
  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stop && !wr_ctrl) |=> !en_q); // R7
  AST_COUNT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_mode && !cnt_edge && !wr_count && !crst_q) |=> $stable(tc_q)); // R4
endmodule

// File: tb/mc_timer_tb.sv
`timescale 1ns/1ps
module mc_timer_tb_top;
  import mct_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  cap_in = '0;
  logic [3:0]  mat_out;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  mc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .mat_out(mat_out), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdchk(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse1(int n);
    @(negedge clk); cap_in[n] = 1'b1;
    repeat (3) @(negedge clk);
    cap_in[n] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R1 register field widths and read-only indices, R2 count write held in reset
  localparam int NV = 14;
  localparam logic [3:0]  V_ADDR [NV] = '{4'd1, 4'd5, 4'd10, 4'd13, 4'd14, 4'd3, 4'd9,
                                          4'd11, 4'd4, 4'd2, 4'd5, 4'd10, 4'd13, 4'd14};
  localparam logic [31:0] V_DATA [NV] = '{32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hA5A5_A5A5,
                                          32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                          32'h0000_BEEF, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] V_EXP  [NV] = '{32'h2, 32'hFFF, 32'h3F, 32'hFFF, 32'hF,
                                          32'hA5A5_A5A5, 32'h1234_5678, 32'h0, 32'h0,
                                          32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam int          V_REQ  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 2, 1, 1, 1, 1};

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1, R2, R11)
    rdchk("R2 reset count", 4'd2, 32'h0);
    rdchk("R2 reset control", 4'd1, 32'h0);
    chk("R8 reset outputs", {28'h0, mat_out}, 32'h0);
    chk("R11 reset irq", {31'h0, irq}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rdchk($sformatf("R%0d reg %0d", V_REQ[i], V_ADDR[i]), V_ADDR[i], V_EXP[i]);
    end
    wr(4'd1, 32'h0);

    // R3 timer mode with prescale limit 2
    wr(4'd1, 32'h2);
    wr(4'd3, 32'h2);
    wr(4'd1, 32'h1);
    repeat (9) @(negedge clk);
    rdchk("R3 count after 9 clocks", 4'd2, 32'd3);
    rdchk("R3 prescale at wrap", 4'd4, 32'd0);
    @(negedge clk);
    rdchk("R3 prescale one later", 4'd4, 32'd1);

    // R5 R6 R8 compare 0 = 5 with flag, reset and toggle
    wr(4'd1, 32'h2);
    wr(4'd3, 32'h0);
    wr(4'd6, 32'd5);
    wr(4'd5, 32'h3);
    wr(4'd13, 32'h30);
    wr(4'd0, 32'h3F);
    wr(4'd1, 32'h1);
    repeat (5) @(negedge clk);
    rdchk("R6 count reaches 5", 4'd2, 32'd5);
    rdchk("R5 no flag before event", 4'd0, 32'h0);
    @(negedge clk);
    rdchk("R6 count wraps to 0", 4'd2, 32'd0);
    rdchk("R5 flag 0 set", 4'd0, 32'h1);
    chk("R8 toggle high", {28'h0, mat_out}, 32'h1);
    chk("R11 irq high", {31'h0, irq}, 32'h1);
    repeat (6) @(negedge clk);
    rdchk("R6 count wraps again", 4'd2, 32'd0);
    chk("R8 toggle low", {28'h0, mat_out}, 32'h0);

    // R11 clear on the event edge: set wins
    repeat (4) @(negedge clk);
    wr(4'd0, 32'h1);
    rdchk("R11 set wins over clear", 4'd0, 32'h1);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h1);
    rdchk("R11 clear works", 4'd0, 32'h0);
    chk("R11 irq low", {31'h0, irq}, 32'h0);

    // R7 R8 stop on channel 1, actions on 1..3
    wr(4'd1, 32'h2);
    wr(4'd6, 32'd100);
    wr(4'd7, 32'd3);
    wr(4'd8, 32'd3);
    wr(4'd9, 32'd3);
    wr(4'd5, 32'h20);
    wr(4'd13, 32'h18C);
    wr(4'd1, 32'h1);
    repeat (6) @(negedge clk);
    rdchk("R7 count held at match", 4'd2, 32'd3);
    rdchk("R7 enable cleared", 4'd1, 32'h0);
    chk("R8 high/low/keep actions", {28'h0, mat_out}, 32'hA);
    rdchk("R5 no flag when disabled", 4'd0, 32'h0);

    // R9 R10 capture with counter halted
    wr(4'd5, 32'h0);
    wr(4'd13, 32'h0);
    wr(4'd2, 32'h1234);
    wr(4'd10, 32'h15);
    @(negedge clk); cap_in = 2'b11;
    repeat (4) @(negedge clk);
    rdchk("R9 capture 0 on rise", 4'd11, 32'h1234);
    rdchk("R9 capture 1 ignores rise", 4'd12, 32'h0);
    rdchk("R10 capture 0 flag", 4'd0, 32'h10);
    wr(4'd2, 32'h55);
    @(negedge clk); cap_in = 2'b00;
    repeat (4) @(negedge clk);
    rdchk("R9 capture 0 ignores fall", 4'd11, 32'h1234);
    rdchk("R9 capture 1 on fall", 4'd12, 32'h55);
    rdchk("R10 no flag without enable", 4'd0, 32'h10);
    wr(4'd10, 32'h3);
    wr(4'd2, 32'h77);
    @(negedge clk); cap_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    rdchk("R9 any edge rise", 4'd11, 32'h77);
    wr(4'd2, 32'h88);
    @(negedge clk); cap_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    rdchk("R9 any edge fall", 4'd11, 32'h88);

    // R4 R12 counter mode on cap_in[1]
    wr(4'd1, 32'h2);
    wr(4'd0, 32'h3F);
    wr(4'd14, 32'h5);
    wr(4'd10, 32'h08);
    wr(4'd1, 32'h1);
    pulse1(1); pulse1(1); pulse1(1);
    rdchk("R4 rising count", 4'd2, 32'd3);
    rdchk("R12 capture on count pin", 4'd12, 32'd2);
    pulse1(0);
    rdchk("R4 other pin ignored", 4'd2, 32'd3);
    wr(4'd14, 32'h7);
    pulse1(1); pulse1(1);
    rdchk("R4 both edges count", 4'd2, 32'd7);
    rdchk("R12 capture before increment", 4'd12, 32'd5);
    wr(4'd14, 32'h6);
    pulse1(1);
    rdchk("R4 falling count", 4'd2, 32'd8);
    rdchk("R12 capture in falling mode", 4'd12, 32'd7);
    wr(4'd14, 32'hD);
    pulse1(1); pulse1(0);
    rdchk("R4 source code 3 counts nothing", 4'd2, 32'd8);

    finish_run();
  end
endmodule